// File: doc/BRIEF.md
# Multicycle RISC Datapath Core

This block is the datapath half of a small 32-bit processor that runs each instruction over several clock cycles. It implements register-register arithmetic (add, sub, and, or, slt), OR with an immediate, word load, word store and branch-on-equal. It contains the program counter, an instruction register, a 32-entry register file, one shared ALU, a branch-target register and the multiplexers that steer operands and write-back data. A single dual-port memory outside the block holds both instructions and data. The block drives that memory's read word address, write word address, write data and write enable, and it takes in the read data.

The block does no sequencing of its own. An external controller drives every steering and enable input in every cycle. In return the block gives the controller the opcode and function fields of the held instruction and the ALU zero flag. No registers sit between the register-file read ports, the ALU and the write-back path. Because of this, a register-register operation can compute its result and write it back in the same cycle, provided the instruction register and the steering inputs stay unchanged. The branch target is computed during the decode step and kept in a dedicated register, so the ALU is free to do the comparison in the next step.

Top module: `mc_datapath`

## Requirements
- R1: An active-low reset, asserted asynchronously, clears the PC, the instruction register and the target register to zero; while it is low, with `addr_sel`=0, `mem_rd_word` is 0.
- R2: ALU operand A is the PC when `sel_a`=0 and register-file read port A when `sel_a`=1.
- R3: ALU operand B is picked by `sel_b`: 00 gives the constant 4, 01 gives read port B, 10 gives the extended immediate shifted left by 2, 11 gives the extended immediate unshifted.
- R4: `mem_rd_word` is bits 31:2 of the PC when `addr_sel`=0 and bits 31:2 of the ALU result when `addr_sel`=1, so the two low address bits have no effect. `mem_wr_word` is ALU result bits 31:2, `mem_wr_data` is read port B, and `mem_wr_en` follows `mem_we_in`.
- R5: The PC is loaded when `pc_we`=1, or when `pc_we_cond`=1 and `zero`=1; otherwise it holds. When loaded, it takes the ALU result if `pc_src`=0 and the target register if `pc_src`=1.
- R6: The target register takes the ALU result at a clock edge where `tgt_we`=1 and holds in every other cycle.
- R7: Read port A is addressed by instruction bits 25:21 and read port B by bits 20:16. The write address is bits 20:16 when `wb_dst_rd`=0 and bits 15:11 when `wb_dst_rd`=1. A write takes place at a clock edge with `rf_we`=1.
- R8: Write-back data is the ALU result when `wb_from_mem`=0 and `mem_rd_data` when `wb_from_mem`=1.
- R9: The 16-bit immediate in instruction bits 15:0 is sign-extended when `ext_sign`=1 and zero-extended when `ext_sign`=0.
- R10: The instruction register loads `mem_rd_data` only at an edge with `ir_we`=1. `opcode` shows its bits 31:26 and `funct` shows its bits 5:0.
- R11: `alu_op` codes: 0 add, 1 subtract, 2 or, 3 and, 4 decode `funct` (0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than giving 1 or 0). `zero` is 1 exactly when the ALU result is all zeros.
- R12: Register 0 always reads as zero, and writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pc_we | input | 1 | Unconditional PC load |
| pc_we_cond | input | 1 | PC load when zero flag is set |
| pc_src | input | 1 | PC source: 0 ALU result, 1 target register |
| ir_we | input | 1 | Instruction register load |
| tgt_we | input | 1 | Target register load |
| sel_a | input | 1 | ALU operand A select |
| sel_b | input | 2 | ALU operand B select |
| alu_op | input | 3 | ALU operation code |
| ext_sign | input | 1 | 1 sign-extend, 0 zero-extend immediate |
| addr_sel | input | 1 | Read address: 0 PC, 1 ALU result |
| wb_dst_rd | input | 1 | Write address: 0 bits 20:16, 1 bits 15:11 |
| wb_from_mem | input | 1 | Write-back data: 0 ALU, 1 memory |
| rf_we | input | 1 | Register file write enable |
| mem_we_in | input | 1 | Memory write request from controller |
| mem_rd_data | input | 32 | Memory read data |
| mem_rd_word | output | 30 | Memory read word address |
| mem_wr_word | output | 30 | Memory write word address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_en | output | 1 | Memory write enable |
| opcode | output | 6 | Held instruction bits 31:26 |
| funct | output | 6 | Held instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |

## Verification
The ALU path is driven from a vector table of operand pairs under each function code and each direct operation code. The table includes a carry wrap to zero, a negative difference and signed comparisons on both sides of zero, so an unsigned compare or a wrong code decode shows up as a different written-back value. Instruction sequences then exercise PC stepping by 4, a taken and a not-taken branch, and a backward target built from a negative offset. Loads and stores are tried with immediates whose extension differs between sign and zero mode, and with offsets that touch only the low address bits. A final set of patterns aims write-back at rt versus rd, whose fields differ within one instruction, at register 0, and asserts reset mid-run.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;

  typedef enum logic [2:0] {
    ALU_ADD   = 3'd0,
    ALU_SUB   = 3'd1,
    ALU_OR    = 3'd2,
    ALU_AND   = 3'd3,
    ALU_RTYPE = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    OPB_FOUR   = 2'b00,
    OPB_REGB   = 2'b01,
    OPB_IMM_SH = 2'b10,
    OPB_IMM    = 2'b11
  } opb_sel_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;

endpackage

// File: rtl/mc_dp_immext.sv
module mc_dp_immext #(
  parameter int IW = 16,
  parameter int OW = 32
) (
  input  logic [IW-1:0] imm,
  input  logic          sign_en,
  output logic [OW-1:0] ext
);
  localparam int PAD = OW - IW;

  logic fill;

  always_comb begin
    fill = sign_en & imm[IW-1];
    ext  = {{PAD{fill}}, imm};
  end
endmodule

// File: rtl/mc_dp_alu.sv
module mc_dp_alu
  import mc_dp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  input  logic [5:0]   fn,
  output logic [W-1:0] res,
  output logic         zero
);
  typedef enum logic [2:0] {K_ADD, K_SUB, K_OR, K_AND, K_SLT} kind_e;

  kind_e kind;
  logic  lt;

  always_comb begin
    kind = K_ADD;
    case (op)
      ALU_SUB: kind = K_SUB;
      ALU_OR:  kind = K_OR;
      ALU_AND: kind = K_AND;
      ALU_RTYPE: begin
        case (fn)
          FN_SUB:  kind = K_SUB;
          FN_AND:  kind = K_AND;
          FN_OR:   kind = K_OR;
          FN_SLT:  kind = K_SLT;
          default: kind = K_ADD;
        endcase
      end
      default: kind = K_ADD;
    endcase
  end

  always_comb begin
    lt = $signed(a) < $signed(b);
    case (kind)
      K_SUB:   res = a - b;
      K_OR:    res = a | b;
      K_AND:   res = a & b;
      K_SLT:   res = {{(W-1){1'b0}}, lt};
      default: res = a + b;
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/mc_dp_regfile.sv
module mc_dp_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs [N];
  logic         wr_en;

  always_comb wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      regs[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_dp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG),
  localparam int WAW = XLEN - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_we,
  input  logic            pc_we_cond,
  input  logic            pc_src,
  input  logic            ir_we,
  input  logic            tgt_we,
  input  logic            sel_a,
  input  logic [1:0]      sel_b,
  input  logic [2:0]      alu_op,
  input  logic            ext_sign,
  input  logic            addr_sel,
  input  logic            wb_dst_rd,
  input  logic            wb_from_mem,
  input  logic            rf_we,
  input  logic            mem_we_in,
  input  logic [XLEN-1:0] mem_rd_data,
  output logic [WAW-1:0]  mem_rd_word,
  output logic [WAW-1:0]  mem_wr_word,
  output logic [XLEN-1:0] mem_wr_data,
  output logic            mem_wr_en,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            zero
);
  // state and next-state
  logic [XLEN-1:0]   pc_q, pc_d;
  logic [INSN_W-1:0] ir_q, ir_d;
  logic [XLEN-1:0]   tgt_q, tgt_d;
  logic              pc_en;

  // datapath nets
  logic [XLEN-1:0] bus_a, bus_b;
  logic [XLEN-1:0] opnd_a, opnd_b;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] alu_res;
  logic [XLEN-1:0] wb_data;
  logic [RAW-1:0]  rs_f, rt_f, rd_f, wb_addr;

  always_comb begin
    rs_f = ir_q[21 +: RAW];
    rt_f = ir_q[16 +: RAW];
    rd_f = ir_q[11 +: RAW];
    opcode = ir_q[31:26];
    funct  = ir_q[5:0];
  end

  mc_dp_immext #(.IW(IMM_W), .OW(XLEN)) i_immext (
    .imm     (ir_q[IMM_W-1:0]),
    .sign_en (ext_sign),
    .ext     (imm_ext)
  );

  mc_dp_regfile #(.W(XLEN), .N(NREG)) i_regfile (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (rs_f),
    .raddr_b (rt_f),
    .rdata_a (bus_a),
    .rdata_b (bus_b)
  );

  // operand steering
  always_comb begin
    opnd_a = sel_a ? bus_a : pc_q;
    case (opb_sel_e'(sel_b))
      OPB_FOUR:   opnd_b = XLEN'(4);
      OPB_REGB:   opnd_b = bus_b;
      OPB_IMM_SH: opnd_b = {imm_ext[XLEN-3:0], 2'b00};
      default:    opnd_b = imm_ext;
    endcase
  end

  mc_dp_alu #(.W(XLEN)) i_alu (
    .a    (opnd_a),
    .b    (opnd_b),
    .op   (alu_op),
    .fn   (ir_q[5:0]),
    .res  (alu_res),
    .zero (zero)
  );

  // write-back steering
  always_comb begin
    wb_addr = wb_dst_rd ? rd_f : rt_f;
    wb_data = wb_from_mem ? mem_rd_data : alu_res;
  end

  // memory side
  always_comb begin
    mem_rd_word = addr_sel ? alu_res[XLEN-1:2] : pc_q[XLEN-1:2];
    mem_wr_word = alu_res[XLEN-1:2];
    mem_wr_data = bus_b;
    mem_wr_en   = mem_we_in;
  end

  // next-state
  always_comb begin
    pc_en = pc_we | (pc_we_cond & zero);
    pc_d  = pc_q;
    if (pc_en) begin
      pc_d = pc_src ? tgt_q : alu_res;
    end
    ir_d = ir_q;
    if (ir_we) begin
      ir_d = mem_rd_data[INSN_W-1:0];
    end
    tgt_d = tgt_q;
    if (tgt_we) begin
      tgt_d = alu_res;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      tgt_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      tgt_q <= tgt_d;
    end
  end
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pc_we,
  input logic            pc_we_cond,
  input logic            pc_src,
  input logic            ir_we,
  input logic            tgt_we,
  input logic            zero,
  input logic [XLEN-1:0] mem_rd_data,
  input logic [XLEN-1:0] pc_q,
  input logic [31:0]     ir_q,
  input logic [XLEN-1:0] tgt_q,
  input logic [XLEN-1:0] alu_res,
  input logic [XLEN-1:0] bus_a
);
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && !pc_we_cond) |=> $stable(pc_q)); // R5

  AST_PC_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_we && pc_we_cond && !zero) |=> $stable(pc_q)); // R5

  AST_PC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we_cond && zero && pc_src) |=> (pc_q == $past(tgt_q))); // R5

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_we |=> $stable(ir_q)); // R10

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> (ir_q == $past(mem_rd_data[31:0]))); // R10

  AST_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_we |=> $stable(tgt_q)); // R6

  AST_TGT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we |=> (tgt_q == $past(alu_res))); // R6

  AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[25:21] == 5'd0) |-> (bus_a == '0)); // R12
endmodule

bind mc_datapath mc_datapath_chk #(.XLEN(XLEN)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pc_we       (pc_we),
  .pc_we_cond  (pc_we_cond),
  .pc_src      (pc_src),
  .ir_we       (ir_we),
  .tgt_we      (tgt_we),
  .zero        (zero),
  .mem_rd_data (mem_rd_data),
  .pc_q        (pc_q),
  .ir_q        (ir_q),
  .tgt_q       (tgt_q),
  .alu_res     (alu_res),
  .bus_a       (bus_a)
);

// File: tb/test_mc_datapath.sv
`timescale 1ns/1ps
module test_mc_datapath;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pc_we, pc_we_cond, pc_src, ir_we, tgt_we, sel_a;
  logic [1:0]  sel_b;
  logic [2:0]  alu_op;
  logic        ext_sign, addr_sel, wb_dst_rd, wb_from_mem, rf_we, mem_we_in;
  logic [31:0] mem_rd_data;
  logic [29:0] mem_rd_word, mem_wr_word;
  logic [31:0] mem_wr_data;
  logic        mem_wr_en;
  logic [5:0]  opcode, funct;
  logic        zero;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mc_datapath i_mc_datapath (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .pc_src(pc_src), .ir_we(ir_we), .tgt_we(tgt_we), .sel_a(sel_a),
    .sel_b(sel_b), .alu_op(alu_op), .ext_sign(ext_sign), .addr_sel(addr_sel),
    .wb_dst_rd(wb_dst_rd), .wb_from_mem(wb_from_mem), .rf_we(rf_we),
    .mem_we_in(mem_we_in), .mem_rd_data(mem_rd_data), .mem_rd_word(mem_rd_word),
    .mem_wr_word(mem_wr_word), .mem_wr_data(mem_wr_data), .mem_wr_en(mem_wr_en),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{3'd4, 6'h20, 32'd5,         32'd7,         32'd12},
    '{3'd4, 6'h22, 32'd3,         32'd5,         32'hFFFF_FFFE},
    '{3'd4, 6'h24, 32'hF0F0_F0F0, 32'h3C3C_3C3C, 32'h3030_3030},
    '{3'd4, 6'h25, 32'hF0F0_0000, 32'h0000_ABCD, 32'hF0F0_ABCD},
    '{3'd4, 6'h2A, 32'hFFFF_FFFF, 32'd1,         32'd1},
    '{3'd4, 6'h2A, 32'd7,         32'hFFFF_FFF0, 32'd0},
    '{3'd1, 6'h20, 32'd9,         32'd2,         32'd7},
    '{3'd2, 6'h20, 32'h0000_1200, 32'h0000_0034, 32'h0000_1234},
    '{3'd3, 6'h25, 32'hFF00_FF00, 32'h0FF0_0FF0, 32'h0F00_0F00},
    '{3'd0, 6'h22, 32'hFFFF_FFFF, 32'd1,         32'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pc_we = 0; pc_we_cond = 0; pc_src = 0; ir_we = 0; tgt_we = 0;
    sel_a = 0; sel_b = 2'b00; alu_op = 3'd0; ext_sign = 0; addr_sel = 0;
    wb_dst_rd = 0; wb_from_mem = 0; rf_we = 0; mem_we_in = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_ir(input logic [31:0] ins);
    idle();
    mem_rd_data = ins;
    ir_we = 1;
    step();
    ir_we = 0;
  endtask

  task automatic write_reg(input logic [4:0] r, input logic [31:0] v);
    load_ir({6'h23, 5'd0, r, 16'h0000});
    mem_rd_data = v;
    wb_from_mem = 1;
    rf_we = 1;
    step();
    idle();
  endtask

  task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
    load_ir({6'h2b, 5'd0, r, 16'h0000});
    #0.1 v = mem_wr_data;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle();
    mem_rd_data = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pc word", {2'b0, mem_rd_word}, 32'd0);
    chk("R1 reset opcode", {26'b0, opcode}, 32'd0);
    rst_n = 1;
    step();

    // ALU vector table: rs=1, rt=2, rd=3
    for (int i = 0; i < NVEC; i++) begin
      write_reg(5'd1, VECS[i].a);
      write_reg(5'd2, VECS[i].b);
      load_ir({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, VECS[i].fn});
      chk("R10 funct field", {26'b0, funct}, {26'b0, VECS[i].fn});
      sel_a = 1; sel_b = 2'b01; alu_op = VECS[i].op; wb_dst_rd = 1; rf_we = 1;
      #0.1;
      chk("R11 zero flag", {31'b0, zero}, {31'b0, (VECS[i].exp == 32'd0)});
      chk("R4 write word", {2'b0, mem_wr_word}, {2'b0, VECS[i].exp[31:2]});
      step();
      idle();
      read_reg(5'd3, v);
      chk("R11 alu result", v, VECS[i].exp);
      read_reg(5'd2, v);
      chk("R7 rt untouched by rd write", v, VECS[i].b);
    end

    // branch sequence
    write_reg(5'd5, 32'h77);
    write_reg(5'd6, 32'h77);
    write_reg(5'd7, 32'h78);
    chk("R5 pc held without enables", {2'b0, mem_rd_word}, 32'd0);
    idle();
    mem_rd_data = {6'h04, 5'd5, 5'd6, 16'h0003};
    ir_we = 1; pc_we = 1; sel_a = 0; sel_b = 2'b00; alu_op = 3'd0; pc_src = 0;
    step();
    chk("R2 R3 R5 fetch pc+4", {2'b0, mem_rd_word}, 32'd1);
    chk("R10 opcode loaded", {26'b0, opcode}, 32'h04);
    idle();
    mem_rd_data = 32'hFFFF_FFFF;
    sel_a = 0; sel_b = 2'b10; ext_sign = 1; alu_op = 3'd0; tgt_we = 1;
    step();
    chk("R10 ir holds without load", {26'b0, opcode}, 32'h04);
    idle();
    sel_a = 1; sel_b = 2'b01; alu_op = 3'd1; pc_we_cond = 1; pc_src = 1;
    #0.1;
    chk("R11 zero on equal", {31'b0, zero}, 32'd1);
    step();
    chk("R5 R6 branch taken", {2'b0, mem_rd_word}, 32'd4);

    idle();
    mem_rd_data = {6'h04, 5'd5, 5'd7, 16'hFFFE};
    ir_we = 1; pc_we = 1;
    step();
    chk("R5 fetch at 16", {2'b0, mem_rd_word}, 32'd5);
    idle();
    sel_b = 2'b10; ext_sign = 1; tgt_we = 1;
    step();
    idle();
    sel_a = 1; sel_b = 2'b01; alu_op = 3'd1; pc_we_cond = 1; pc_src = 1;
    #0.1;
    chk("R11 zero on unequal", {31'b0, zero}, 32'd0);
    step();
    chk("R5 branch not taken", {2'b0, mem_rd_word}, 32'd5);
    idle();
    sel_a = 1; sel_b = 2'b01; alu_op = 3'd0;
    step();
    idle();
    pc_we = 1; pc_src = 1;
    step();
    idle();
    chk("R6 R9 backward target held", {2'b0, mem_rd_word}, 32'd3);

    // or-immediate: zero extension, write to rt
    write_reg(5'd8, 32'h1234_0000);
    write_reg(5'd16, 32'h5A5A_5A5A);
    load_ir({6'h0d, 5'd8, 5'd9, 16'h8001});
    sel_a = 1; sel_b = 2'b11; ext_sign = 0; alu_op = 3'd2; rf_we = 1;
    step();
    idle();
    read_reg(5'd9, v);
    chk("R9 R8 R3 ori zero-extend", v, 32'h1234_8001);
    read_reg(5'd16, v);
    chk("R7 rd field untouched", v, 32'h5A5A_5A5A);

    // load address and write-back
    write_reg(5'd10, 32'h0000_0100);
    load_ir({6'h23, 5'd10, 5'd11, 16'hFFFC});
    sel_a = 1; sel_b = 2'b11; ext_sign = 1; alu_op = 3'd0; addr_sel = 1;
    #0.1;
    chk("R4 R9 sign-extended address", {2'b0, mem_rd_word}, 32'h3F);
    ext_sign = 0;
    #0.1;
    chk("R9 zero-extended address", {2'b0, mem_rd_word}, 32'h403F);
    ext_sign = 1;
    mem_rd_data = 32'hCAFE_F00D; wb_from_mem = 1; rf_we = 1;
    step();
    idle();
    read_reg(5'd11, v);
    chk("R8 memory write-back", v, 32'hCAFE_F00D);
    load_ir({6'h23, 5'd10, 5'd11, 16'h0003});
    sel_a = 1; sel_b = 2'b11; ext_sign = 1; addr_sel = 1;
    #0.1;
    chk("R4 low address bits ignored", {2'b0, mem_rd_word}, 32'h40);

    // store
    load_ir({6'h2b, 5'd10, 5'd11, 16'h0008});
    sel_a = 1; sel_b = 2'b11; ext_sign = 1; mem_we_in = 1;
    #0.1;
    chk("R4 store enable", {31'b0, mem_wr_en}, 32'd1);
    chk("R4 store word", {2'b0, mem_wr_word}, 32'h42);
    chk("R4 store data", mem_wr_data, 32'hCAFE_F00D);
    mem_we_in = 0;
    #0.1;
    chk("R4 store enable low", {31'b0, mem_wr_en}, 32'd0);
    idle();

    // register 0
    write_reg(5'd0, 32'hDEAD_BEEF);
    read_reg(5'd0, v);
    chk("R12 register 0 reads zero", v, 32'd0);

    // asynchronous reset mid-run
    idle();
    #0.1;
    chk("R5 pc before reset", {2'b0, mem_rd_word}, 32'd3);
    #0.4 rst_n = 0;
    #0.5;
    chk("R1 async reset clears pc", {2'b0, mem_rd_word}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    step();
    chk("R1 pc stays zero after release", {2'b0, mem_rd_word}, 32'd0);

    summary();
    $finish;
  end
endmodule